// File: doc/BRIEF.md
# Interrupt Line to Bus-Write Message Aggregator

This block gathers up to 32 device interrupt lines into a small bank of memory-mapped registers. It signals each enabled interrupt to the processor as one posted 32-bit bus write on a valid/ready master port. Every rising edge on a line is recorded in a pending register, whatever the mask holds. When the line's mask bit is also set, the edge is recorded in a sticky request register and, unless the control register's bus-error bit blocks delivery, one outbound message is queued. The message address and data both come from the single programmable address register. The address is that register with its low 5 bits cleared, and the data is those low 5 bits.

Software reaches the registers over a simple register bus that carries a select, a write flag, a byte address, byte enables and write data. Read data comes back one cycle later with a valid strobe. Any access to the pending register, read or write, clears it. Outbound messages wait in a four-entry queue so that simultaneous edges, or edges that arrive while the master port is stalled, are not lost until the queue is full.

Top module: `irq_msg_aggregator`

## Requirements
- R1: Line n corresponds to bit n of the mask, pending and request registers. The word offsets are 0x00 request, 0x04 mask, 0x08 pending, 0x0C control and 0x10 address, and a read of any other offset returns zero.
- R2: A rising edge on a line sets its pending bit regardless of the mask. A line that stays high sets that bit, and sends a message, only once. A falling edge changes nothing.
- R3: A rising edge on a line whose mask bit is 1 sets its request bit. An edge on a line whose mask bit is 0 leaves the request register unchanged.
- R4: Each rising edge on a masked-in line, with delivery enabled, produces exactly one message. Its address is the address register with bits 4:0 cleared, and its data is the address register's bits 4:0, zero-extended.
- R5: While control bit 0 (bus error) is 1, no message is produced, but request bits are still set.
- R6: A read of the pending register returns its current value and then clears it. A write to it clears it whatever the data is.
- R7: When a pending read coincides with a new rising edge, the read returns the value from before the clear, and the new edge's bit remains set afterwards.
- R8: The request register is read-only. Writes leave it unchanged, and its bits clear only on reset.
- R9: A read of the control register returns bit 0 only, with all other bits zero. A write updates the register from the written data.
- R10: After reset the address register reads 0xFFFB0003, the other registers read zero, and no message is valid.
- R11: Writes are big-endian by byte lane. Enable bit 0 selects data bits 31:24, and enable bit 3 selects bits 7:0. Lanes that are not enabled keep their old contents.
- R12: Messages queue in four entries. A message that is held while ready is low keeps its address and data stable. Edges that arrive while the queue is full produce no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Device interrupt lines, edge-detected |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address of the register |
| bus_be | input | 4 | Byte enables, bit 0 is the most significant byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| msg_valid | output | 1 | Outbound message available |
| msg_addr | output | 32 | Outbound write address |
| msg_data | output | 32 | Outbound write data |
| msg_ready | input | 1 | Master port accepts the message |

## Verification
On every cycle the embedded properties check four things. An edge always lands in the pending register, and a pending access leaves behind only the edges that arrive in the same cycle. Request bits never fall. The queue never overfills, and a stalled message holds still, while a set bus-error bit keeps an idle port idle. The bench's scenarios show the rest: the exact message address and data for each edge, the register read-back and reset values, the clear-on-read ordering against a coinciding edge, the byte-lane mapping, and the drop of messages once the queue is full.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Register word indices (byte address / 4)
  typedef enum logic [2:0] {
    RG_REQ  = 3'd0,
    RG_MASK = 3'd1,
    RG_PEND = 3'd2,
    RG_CTRL = 3'd3,
    RG_ADDR = 3'd4
  } reg_word_e;

  // Bit of the control register that blocks message delivery
  localparam int BUSERR_BIT = 0;

endpackage

// File: rtl/irq_agg_edge.sv
module irq_agg_edge #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines,
  output logic [NUM_LINES-1:0] rise
);

  logic [NUM_LINES-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= lines;
  end

  // One-cycle strobe per low-to-high transition
  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_line
      assign rise[g] = lines[g] & ~level_q[g];
    end
  endgenerate

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 5,
  parameter logic [DATA_W-1:0] RESET_ADDR = 32'hFFFB_0003
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W/8-1:0]   bus_be,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_rvalid,
  input  logic [DATA_W-1:0]     rise,
  output logic [DATA_W-1:0]     fire,
  output logic                  buserr,
  output logic [DATA_W-1:0]     addr_q
);

  localparam int NBYTE  = DATA_W / 8;
  localparam int LANE_W = $clog2(NBYTE);
  localparam int WORD_W = ADDR_W - LANE_W;

  logic [DATA_W-1:0] mask_q, pend_q, req_q, ctrl_q;
  logic [DATA_W-1:0] rd_val;
  logic [WORD_W-1:0] word;
  logic              rd_hit, wr_hit, pend_hit;

  assign word     = bus_addr[ADDR_W-1:LANE_W];
  assign rd_hit   = bus_sel && !bus_wr;
  assign wr_hit   = bus_sel && bus_wr;
  assign pend_hit = bus_sel && (word == WORD_W'(RG_PEND));

  // Big-endian lane merge: enable bit 0 owns the most significant byte
  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [NBYTE-1:0]  be
  );
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int b = 0; b < NBYTE; b++) begin
      if (be[b]) r[DATA_W-1-8*b -: 8] = new_v[DATA_W-1-8*b -: 8];
    end
    return r;
  endfunction

  always_comb begin
    rd_val = '0;
    unique case (word)
      WORD_W'(RG_REQ):  rd_val = req_q;
      WORD_W'(RG_MASK): rd_val = mask_q;
      WORD_W'(RG_PEND): rd_val = pend_q;
      WORD_W'(RG_CTRL): rd_val[BUSERR_BIT] = ctrl_q[BUSERR_BIT];
      WORD_W'(RG_ADDR): rd_val = addr_q;
      default:          rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      pend_q     <= '0;
      req_q      <= '0;
      ctrl_q     <= '0;
      addr_q     <= RESET_ADDR;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_hit;
      if (rd_hit) bus_rdata <= rd_val;
      // clear on any pending access, then fold in this cycle's edges
      pend_q <= (pend_hit ? '0 : pend_q) | rise;
      req_q  <= req_q | (rise & mask_q);
      if (wr_hit) begin
        unique case (word)
          WORD_W'(RG_MASK): mask_q <= lane_merge(mask_q, bus_wdata, bus_be);
          WORD_W'(RG_CTRL): ctrl_q <= lane_merge(ctrl_q, bus_wdata, bus_be);
          WORD_W'(RG_ADDR): addr_q <= lane_merge(addr_q, bus_wdata, bus_be);
          default: ;
        endcase
      end
    end
  end

  assign buserr = ctrl_q[BUSERR_BIT];
  assign fire   = buserr ? '0 : (rise & mask_q);

  // R2: every edge is visible in the pending register one cycle later
  p_pend_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R6 / R7: after a pending access only the coinciding edges remain
  p_pend_clear_r6: assert property (@(posedge clk) disable iff (rst)
    pend_hit |=> (pend_q == $past(rise)));

  // R8: request bits never fall outside reset
  p_req_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ((req_q & $past(req_q)) == $past(req_q)));

endmodule

// File: rtl/irq_agg_msgq.sv
module irq_agg_msgq #(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  parameter int MSG_LSB = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] fire,
  input  logic [DATA_W-1:0] snap,
  input  logic              msg_ready,
  output logic              msg_valid,
  output logic [DATA_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HIT_W = $clog2(DATA_W + 1);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << MSG_LSB) - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [HIT_W-1:0]  hits;
  logic [DATA_W-1:0] head;
  int                free_n, push_n;
  logic              pop;

  always_comb begin
    hits = '0;
    for (int i = 0; i < DATA_W; i++) hits = hits + HIT_W'(fire[i]);
  end

  // accept as many of this cycle's messages as there are free entries
  always_comb begin
    free_n = DEPTH - int'(count);
    push_n = (int'(hits) < free_n) ? int'(hits) : free_n;
  end

  assign pop = msg_valid && msg_ready;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i < push_n) mem[PTR_W'(int'(wr_ptr) + i)] <= snap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= PTR_W'(int'(wr_ptr) + push_n);
      rd_ptr <= rd_ptr + PTR_W'(pop);
      count  <= CNT_W'(int'(count) + push_n - (pop ? 1 : 0));
    end
  end

  assign head      = mem[rd_ptr];
  assign msg_valid = (count != '0);
  assign msg_addr  = head & ~LOW_MASK;
  assign msg_data  = head & LOW_MASK;

  // R12: occupancy bounded by the depth
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    (int'(count) <= DEPTH));

  // R12: a stalled message holds still
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R4: an enabled edge into an empty queue yields a message
  p_accept_r4: assert property (@(posedge clk) disable iff (rst)
    ((|fire) && (count == '0)) |=> msg_valid);

endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator #(
  parameter int                NUM_LINES  = 32,
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 5,
  parameter int                Q_DEPTH    = 4,
  parameter int                MSG_LSB    = 5,
  parameter logic [DATA_W-1:0] RESET_ADDR = 32'hFFFB_0003
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  output logic                msg_valid,
  output logic [DATA_W-1:0]   msg_addr,
  output logic [DATA_W-1:0]   msg_data,
  input  logic                msg_ready
);

  logic [NUM_LINES-1:0] rise;
  logic [DATA_W-1:0]    rise_w, fire_w, addr_w;
  logic                 buserr_w;

  irq_agg_edge #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .lines (irq_in),
    .rise  (rise)
  );

  always_comb begin
    rise_w = '0;
    rise_w[NUM_LINES-1:0] = rise;
  end

  irq_agg_regs #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .rise       (rise_w),
    .fire       (fire_w),
    .buserr     (buserr_w),
    .addr_q     (addr_w)
  );

  irq_agg_msgq #(
    .DATA_W  (DATA_W),
    .DEPTH   (Q_DEPTH),
    .MSG_LSB (MSG_LSB)
  ) u_msgq (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire_w),
    .snap      (addr_w),
    .msg_ready (msg_ready),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
  );

  // R5: with delivery blocked an idle port stays idle
  p_quiet_buserr_r5: assert property (@(posedge clk) disable iff (rst)
    (buserr_w && !msg_valid) |=> !msg_valid);

endmodule

// File: tb/irq_msg_aggregator_bench.sv
module irq_msg_aggregator_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        msg_valid;
  logic [31:0] msg_addr, msg_data;
  logic        msg_ready = 1'b1;

  int errors = 0;
  int checks = 0;
  logic [63:0] exp_q[$];

  logic [31:0] mask_m = '0;
  logic        buserr_m = 1'b0;
  logic [31:0] addr_m = 32'hFFFB_0003;

  always #4 clk = ~clk;

  irq_msg_aggregator u_irq_msg_aggregator (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
    .msg_ready(msg_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // scoreboard driver: expected messages for an edge pattern
  task automatic expect_msgs(input logic [31:0] vec, input int accept);
    int n;
    n = buserr_m ? 0 : $countones(vec & mask_m);
    if (n > accept) n = accept;
    for (int i = 0; i < n; i++) exp_q.push_back({addr_m & ~32'h1F, addr_m & 32'h1F});
  endtask

  task automatic pulse(input logic [31:0] vec, input int accept, input int hold);
    @(negedge clk);
    irq_in = vec;
    expect_msgs(vec, accept);
    repeat (hold) @(negedge clk);
    irq_in = '0;
  endtask

  // pending read in the same cycle as a new edge
  task automatic read_with_edge(input logic [31:0] vec, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h08; irq_in = vec;
    expect_msgs(vec, 32);
    @(negedge clk);
    bus_sel = 1'b0; irq_in = '0;
    d = bus_rdata;
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk);
    #2;
    if (!rst && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4: unexpected message actual=%08h/%08h expected=none", msg_addr, msg_data);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk("R4 msg addr", msg_addr, e[63:32]);
        chk("R4 msg data", msg_data, e[31:0]);
      end
    end
  end

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R10 reset state
    bus_read(5'h00, d); chk("R10 request", d, 32'h0);
    bus_read(5'h04, d); chk("R10 mask", d, 32'h0);
    bus_read(5'h08, d); chk("R10 pending", d, 32'h0);
    bus_read(5'h0C, d); chk("R10 control", d, 32'h0);
    bus_read(5'h10, d); chk("R10 address", d, 32'hFFFB_0003);
    chk("R10 no message", {31'b0, msg_valid}, 32'h0);

    bus_write(5'h04, 32'h0000_0FF0, 4'hF); mask_m = 32'h0000_0FF0;
    bus_read(5'h04, d); chk("R1 mask readback", d, 32'h0000_0FF0);

    // R1 R2 R3 R4: masked-in edge
    pulse(32'h10, 32, 1); tick(4);
    bus_read(5'h08, d); chk("R2 pending set", d, 32'h10);
    bus_read(5'h08, d); chk("R6 read clears", d, 32'h0);
    bus_read(5'h00, d); chk("R3 request set", d, 32'h10);

    // R2 R3: masked-out edge
    pulse(32'h02, 32, 1); tick(3);
    bus_read(5'h08, d); chk("R2 pending ignores mask", d, 32'h02);
    bus_read(5'h00, d); chk("R3 masked-out request", d, 32'h10);

    // R5 R9: bus error blocks messages
    bus_write(5'h0C, 32'hFFFF_FFFF, 4'hF); buserr_m = 1'b1;
    bus_read(5'h0C, d); chk("R9 control reads bit0 only", d, 32'h1);
    pulse(32'h100, 32, 1); tick(4);
    bus_read(5'h00, d); chk("R5 request still latched", d, 32'h110);
    bus_write(5'h0C, 32'h0, 4'hF); buserr_m = 1'b0;
    bus_read(5'h0C, d); chk("R9 control cleared", d, 32'h0);

    // R2: held line, single message
    pulse(32'h20, 32, 5); tick(4);
    bus_read(5'h08, d); chk("R2 pending accumulates", d, 32'h120);
    pulse(32'h40, 32, 1); tick(3);
    bus_write(5'h08, 32'h0, 4'hF);
    bus_read(5'h08, d); chk("R6 write clears", d, 32'h0);

    // R8 read-only request
    bus_write(5'h00, 32'hFFFF_FFFF, 4'hF);
    bus_read(5'h00, d); chk("R8 request unchanged", d, 32'h170);

    // R4 new address, three simultaneous edges
    bus_write(5'h10, 32'h1234_5678, 4'hF); addr_m = 32'h1234_5678;
    bus_read(5'h10, d); chk("R1 address readback", d, 32'h1234_5678);
    pulse(32'hE0, 32, 1); tick(6);

    // R11 byte lanes
    bus_write(5'h04, 32'hAABB_CCDD, 4'b0001);
    bus_read(5'h04, d); chk("R11 lane0 is msb", d, 32'hAA00_0FF0);
    bus_write(5'h04, 32'h1122_3344, 4'b1000);
    bus_read(5'h04, d); chk("R11 lane3 is lsb", d, 32'hAA00_0F44);
    bus_write(5'h04, 32'hFFFF_FFFF, 4'hF); mask_m = 32'hFFFF_FFFF;

    // R7 read coinciding with an edge
    bus_read(5'h08, d);
    pulse(32'h8, 32, 1); tick(3);
    read_with_edge(32'h200, d); chk("R7 pre-clear value", d, 32'h8);
    tick(2);
    bus_read(5'h08, d); chk("R7 new edge kept", d, 32'h200);

    // R12 queue full and drop
    @(negedge clk); msg_ready = 1'b0;
    pulse(32'h3F, 4, 1); tick(3);
    chk("R12 held valid", {31'b0, msg_valid}, 32'h1);
    chk("R12 held address", msg_addr, 32'h1234_5660);
    pulse(32'h400, 0, 1); tick(3);
    @(negedge clk); msg_ready = 1'b1;
    tick(10);
    chk("R12 queue drained", {31'b0, msg_valid}, 32'h0);

    // R1 unmapped offset
    bus_read(5'h14, d); chk("R1 unmapped reads zero", d, 32'h0);

    tick(4);
    chk("R4 all expected messages seen", exp_q.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule